// File: doc/BRIEF.md
# Watchdog and Pushbutton Reset Supervisor

This block holds a microprocessor in reset while its supply is not good, while a reset pushbutton is held, or when the software stops servicing a watchdog. The three causes are merged, and every one of them is stretched so that the reset outputs stay asserted for a fixed 250 ms after the last cause goes away. A divider produces a one-millisecond tick from the system clock, and all timing counts that tick.

The pushbutton input is synchronised and then debounced by a millisecond counter, so short glitches never reach the outputs. The watchdog has no disable. It counts only while the processor runs. It restarts on every high-to-low transition of the strobe input, and it is cleared whenever reset is asserted, so each new window opens at the moment of release. A two-bit select chooses one of three timeout lengths.

The supply condition arrives as a digital power-good bit, synchronised like the other inputs. Two reset outputs of opposite polarity come from separate registers that switch on the same edge.

Top module: `rst_supervisor`

## Requirements
- R1: While `rstN` is low, `rstOut` is 1 and `rstOutN` is 0. After `rstN` rises with `pwrGood` high, the outputs release 250 ms (within one tick plus four clocks) later.
- R2: A low `pwrGood` asserts the reset outputs within three clocks. After `pwrGood` returns high, they stay asserted for 250 ms.
- R3: A low level on `pbN` lasting 20 ms or longer asserts reset. A low pulse shorter than 19 ms has no effect on the outputs.
- R4: After a pushbutton or watchdog cause clears, the outputs stay asserted for 250 ms before release.
- R5: Timeout select `tdSel` encoding: 2'b00 gives 150 ms, 2'b01 gives 610 ms, 2'b10 and 2'b11 give 1200 ms. With no valid strobe inside that window, reset asserts.
- R6: Only a high-to-low transition of `strobe` restarts the watchdog window. A strobe held high or held low does not restart it.
- R7: `strobe` is ignored while reset is asserted. The watchdog window starts from zero at the moment reset releases.
- R8: `rstOut` and `rstOutN` are always complementary.
- R9: A new cause that appears during the 250 ms hold restarts the full hold once it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous block initialisation, active low |
| pwrGood | input | 1 | Supply-in-tolerance flag, high when good |
| pbN | input | 1 | Pushbutton reset request, active low |
| strobe | input | 1 | Watchdog service input, falling edge is valid |
| tdSel | input | 2 | Watchdog timeout select |
| rstOut | output | 1 | Reset to the processor, active high |
| rstOutN | output | 1 | Reset to the processor, active low |

## Verification
The interesting overlap is between the hold timer and a fresh reset cause. A power drop is injected halfway through a pushbutton-initiated hold, and the release is judged against 250 ms measured from the power return, not from the button release. A second overlap is the watchdog expiring in the same cycle that strobes land during reset. Strobes are toggled throughout a watchdog-initiated hold, and the bench confirms that the release time is unchanged and that the next window is the full select period measured from release. A behavioural reference model predicts both outputs on every clock.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    SUP_RUN    = 2'd0,
    SUP_ASSERT = 2'd1,
    SUP_HOLD   = 2'd2
  } supState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic holdRun;   // hold timer may count
    logic wdRun;     // watchdog may count
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic pwrLow;
    logic pbHeld;
    logic wdExpired;
    logic holdDone;
  } dpStatus_t;

endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= INIT;
      else if (s == 0) chain[s] <= din;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rsv_datapath.sv
module rsv_datapath
  import rsv_pkg::*;
#(
  parameter int TICK_DIV    = 125000,
  parameter int DEBOUNCE_MS = 20,
  parameter int HOLD_MS     = 250,
  parameter int WD_SHORT_MS = 150,
  parameter int WD_MED_MS   = 610,
  parameter int WD_LONG_MS  = 1200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrGood,
  input  logic        pbN,
  input  logic        strobe,
  input  logic [1:0]  tdSel,
  input  ctrlStrobe_t ctl,
  output dpStatus_t   stat
);
  localparam int WD_MAX  = (WD_LONG_MS > WD_MED_MS) ?
                           ((WD_LONG_MS > WD_SHORT_MS) ? WD_LONG_MS : WD_SHORT_MS) :
                           ((WD_MED_MS > WD_SHORT_MS) ? WD_MED_MS : WD_SHORT_MS);
  localparam int CNT_MAX = (WD_MAX > HOLD_MS) ?
                           ((WD_MAX > DEBOUNCE_MS) ? WD_MAX : DEBOUNCE_MS) :
                           ((HOLD_MS > DEBOUNCE_MS) ? HOLD_MS : DEBOUNCE_MS);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] DEB_C    = CNT_W'(DEBOUNCE_MS);
  localparam logic [CNT_W-1:0] HOLD_C   = CNT_W'(HOLD_MS);

  // synchronised inputs: {power good, button, strobe}
  logic [2:0] syncOut;
  logic pgSync, pbSync, stSync;

  rsv_sync #(.WIDTH(3), .STAGES(2), .INIT(3'b010)) inSync (
    .clk (clk),
    .rstN(rstN),
    .din ({pwrGood, pbN, strobe}),
    .dout(syncOut)
  );
  assign {pgSync, pbSync, stSync} = syncOut;

  // millisecond tick
  logic [DIV_W-1:0] divCnt;
  logic tick;
  assign tick = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // strobe falling edge
  logic stPrev, fallEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stPrev <= 1'b0;
    else       stPrev <= stSync;
  end
  assign fallEdge = stPrev & ~stSync;

  // timeout selection
  logic [CNT_W-1:0] wdLimit;
  always_comb begin
    case (tdSel)
      2'b00:   wdLimit = CNT_W'(WD_SHORT_MS);
      2'b01:   wdLimit = CNT_W'(WD_MED_MS);
      default: wdLimit = CNT_W'(WD_LONG_MS);
    endcase
  end

  // debounce counter: ticks of continuous low on the button
  logic [CNT_W-1:0] dbCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     dbCnt <= '0;
    else if (pbSync)               dbCnt <= '0;
    else if (tick && dbCnt < DEB_C) dbCnt <= dbCnt + 1'b1;
  end

  // watchdog counter
  logic [CNT_W-1:0] wdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        wdCnt <= '0;
    else if (!ctl.wdRun || fallEdge)  wdCnt <= '0;
    else if (tick && wdCnt < wdLimit) wdCnt <= wdCnt + 1'b1;
  end

  // reset stretch counter
  logic [CNT_W-1:0] holdCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         holdCnt <= '0;
    else if (!ctl.holdRun)             holdCnt <= '0;
    else if (tick && holdCnt < HOLD_C) holdCnt <= holdCnt + 1'b1;
  end

  assign stat.pwrLow    = ~pgSync;
  assign stat.pbHeld    = (dbCnt >= DEB_C);
  assign stat.wdExpired = (wdCnt >= wdLimit);
  assign stat.holdDone  = (holdCnt >= HOLD_C);
endmodule

// File: rtl/rsv_ctrl.sv
module rsv_ctrl
  import rsv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   stat,
  output ctrlStrobe_t ctl,
  output logic        rstHi,
  output logic        rstLo
);
  supState_e state, nextState;
  logic cause;

  assign cause = stat.pwrLow | stat.pbHeld | stat.wdExpired;

  always_comb begin
    nextState = state;
    if (cause) nextState = SUP_ASSERT;
    else begin
      case (state)
        SUP_ASSERT: nextState = SUP_HOLD;
        SUP_HOLD:   if (stat.holdDone) nextState = SUP_RUN;
        default:    nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SUP_ASSERT;
      rstHi <= 1'b1;
      rstLo <= 1'b0;
    end else begin
      state <= nextState;
      rstHi <= (nextState != SUP_RUN);
      rstLo <= (nextState == SUP_RUN);
    end
  end

  assign ctl.holdRun = (state == SUP_HOLD);
  assign ctl.wdRun   = (state == SUP_RUN);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int TICK_DIV    = 125000,
  parameter int DEBOUNCE_MS = 20,
  parameter int HOLD_MS     = 250,
  parameter int WD_SHORT_MS = 150,
  parameter int WD_MED_MS   = 610,
  parameter int WD_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       pbN,
  input  logic       strobe,
  input  logic [1:0] tdSel,
  output logic       rstOut,
  output logic       rstOutN
);
  ctrlStrobe_t ctl;
  dpStatus_t   stat;

  rsv_datapath #(
    .TICK_DIV(TICK_DIV), .DEBOUNCE_MS(DEBOUNCE_MS), .HOLD_MS(HOLD_MS),
    .WD_SHORT_MS(WD_SHORT_MS), .WD_MED_MS(WD_MED_MS), .WD_LONG_MS(WD_LONG_MS)
  ) dp (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .pbN(pbN),
    .strobe(strobe), .tdSel(tdSel), .ctl(ctl), .stat(stat)
  );

  rsv_ctrl ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl),
    .rstHi(rstOut), .rstLo(rstOutN)
  );
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int TICK_DIV    = 125000,
  parameter int DEBOUNCE_MS = 20,
  parameter int HOLD_MS     = 250
) (
  input logic clk,
  input logic rstN,
  input logic pwrGood,
  input logic pbN,
  input logic rstOut,
  input logic rstOutN
);
  localparam int PB_LIMIT   = (DEBOUNCE_MS + 1) * TICK_DIV + 4;
  localparam int QUIET_NEED = (HOLD_MS - 1) * TICK_DIV;

  int pbLowCyc, quietCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pbLowCyc <= 0;
      quietCyc <= 0;
    end else begin
      if (pbN) pbLowCyc <= 0;
      else if (pbLowCyc < PB_LIMIT) pbLowCyc <= pbLowCyc + 1;
      if (!(pbN && pwrGood)) quietCyc <= 0;
      else if (quietCyc < QUIET_NEED) quietCyc <= quietCyc + 1;
    end
  end

  // R1
  por_chk: assert property (@(posedge clk) !rstN |-> (rstOut && !rstOutN));

  // R8
  compl_chk: assert property (@(posedge clk) disable iff (!rstN) rstOut != rstOutN);

  // R2
  pwr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!pwrGood, 3) |-> rstOut);

  // R3
  pb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pbLowCyc >= PB_LIMIT) |-> rstOut);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOut) |-> (quietCyc >= QUIET_NEED));
endmodule

bind rst_supervisor rsv_checker #(
  .TICK_DIV(TICK_DIV), .DEBOUNCE_MS(DEBOUNCE_MS), .HOLD_MS(HOLD_MS)
) chkInst (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .pbN(pbN),
  .rstOut(rstOut), .rstOutN(rstOutN)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
  localparam int DIV  = 4;
  localparam int DEB  = 20;
  localparam int HOLD = 250;
  localparam int HOLD_CYC = HOLD * DIV;

  logic clk = 1'b0;
  logic rstN, pwrGood, pbN, strobe;
  logic [1:0] tdSel;
  logic rstOut, rstOutN;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";

  always #4 clk = ~clk;

  rst_supervisor #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .pbN(pbN),
    .strobe(strobe), .tdSel(tdSel), .rstOut(rstOut), .rstOutN(rstOutN)
  );

  // ---------------- behavioural reference ----------------
  function automatic int limMs(input logic [1:0] s);
    if (s == 2'b00) return 150;
    if (s == 2'b01) return 610;
    return 1200;
  endfunction

  int mDiv, mDb, mWd, mHold, mState; // state: 0 run, 1 assert, 2 hold
  logic mPg1, mPg2, mPb1, mPb2, mSt1, mSt2, mStPrev;
  logic mExp;
  bit started = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mDb = 0; mWd = 0; mHold = 0; mState = 1;
      mPg1 = 0; mPg2 = 0; mPb1 = 1; mPb2 = 1; mSt1 = 0; mSt2 = 0; mStPrev = 0;
      mExp = 1; started = 1;
    end else begin
      automatic bit tick  = (mDiv == DIV - 1);
      automatic bit fall  = mStPrev && !mSt2;
      automatic bit cause = !mPg2 || (mDb >= DEB) || (mWd >= limMs(tdSel));
      automatic int nState = mState;
      if (cause) nState = 1;
      else if (mState == 1) nState = 2;
      else if (mState == 2 && mHold >= HOLD) nState = 0;
      mHold = (mState == 2) ? ((tick && mHold < HOLD) ? mHold + 1 : mHold) : 0;
      mWd   = (mState == 0) ? (fall ? 0 : ((tick && mWd < limMs(tdSel)) ? mWd + 1 : mWd)) : 0;
      mDb   = mPb2 ? 0 : ((tick && mDb < DEB) ? mDb + 1 : mDb);
      mDiv  = tick ? 0 : mDiv + 1;
      mStPrev = mSt2; mSt2 = mSt1; mSt1 = strobe;
      mPg2 = mPg1; mPg1 = pwrGood;
      mPb2 = mPb1; mPb1 = pbN;
      mState = nState;
      mExp = (nState != 0);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (rstOut !== mExp || rstOutN !== !mExp) begin
        fails++;
        $display("FAIL %s per-cycle: rstOut=%b rstOutN=%b expected %b/%b",
                 curReq, rstOut, rstOutN, mExp, !mExp);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: measured %0d cycles, expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitOut(input logic lvl, input int maxCyc, output int n);
    n = 0;
    while (rstOut !== lvl && n < maxCyc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic countHigh(input int cyc, output int hi);
    hi = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rstOut) hi++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int n;
    rstN = 1'b1; pwrGood = 1'b1; pbN = 1'b1; strobe = 1'b0; tdSel = 2'b00;
    #2 rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1, R8: reset state
    checkEq("R1 reset rstOut", rstOut, 1);
    checkEq("R8 reset rstOutN", rstOutN, 0);
    rstN = 1'b1;
    waitOut(1'b0, 2000, n);
    checkRange("R1 power-on hold", n, HOLD_CYC, HOLD_CYC + 12);

    // R6: periodic falling strobes keep the processor running
    curReq = "R6";
    begin
      int hiCnt, tot;
      tot = 0;
      for (int k = 0; k < 6; k++) begin
        countHigh(400, hiCnt);
        tot += hiCnt;
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
      end
      checkEq("R6 serviced watchdog keeps rstOut low", tot, 0);
    end
    // R5 short window, strobe held low
    curReq = "R5";
    waitOut(1'b1, 1000, n);
    checkRange("R5 short timeout 2'b00", n, 150*DIV - 4, 150*DIV + 12);

    // R7: strobes during reset are ignored; R4 watchdog stretch
    curReq = "R7";
    tdSel = 2'b01;
    begin
      int elapsed;
      elapsed = 0;
      for (int k = 0; k < 8; k++) begin
        repeat (50) @(negedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        elapsed += 51;
      end
      waitOut(1'b0, 1500, n);
      checkRange("R7 release time unaffected by strobes", n + elapsed, HOLD_CYC, HOLD_CYC + 12);
    end
    // R5 medium, R6 strobe held high does not restart
    curReq = "R5";
    strobe = 1'b1;
    waitOut(1'b1, 3000, n);
    checkRange("R5 R6 medium timeout 2'b01, level held high", n, 610*DIV - 4, 610*DIV + 8);
    strobe = 1'b0;
    tdSel = 2'b10;
    waitOut(1'b0, 1500, n);
    checkRange("R4 watchdog reset stretch", n, HOLD_CYC - 8, HOLD_CYC + 12);
    waitOut(1'b1, 6000, n);
    checkRange("R5 long timeout 2'b10", n, 1200*DIV - 4, 1200*DIV + 8);
    tdSel = 2'b11;
    waitOut(1'b0, 1500, n);
    waitOut(1'b1, 6000, n);
    checkRange("R5 select 2'b11 maps to long", n, 1200*DIV - 4, 1200*DIV + 8);
    tdSel = 2'b10;
    waitOut(1'b0, 1500, n);

    // R3: short pulse ignored, long pulse recognised
    curReq = "R3";
    begin
      int hiCnt;
      pbN = 1'b0;
      repeat (40) @(negedge clk);
      pbN = 1'b1;
      countHigh(200, hiCnt);
      checkEq("R3 10 ms pulse ignored", hiCnt, 0);
    end
    pbN = 1'b0;
    waitOut(1'b1, 200, n);
    checkRange("R3 20 ms hold recognised", n, DEB*DIV - 4, DEB*DIV + 8);
    repeat (100) @(negedge clk);
    curReq = "R4";
    pbN = 1'b1;
    waitOut(1'b0, 1500, n);
    checkRange("R4 pushbutton stretch", n, HOLD_CYC, HOLD_CYC + 12);

    // R2: power fail in run
    curReq = "R2";
    pwrGood = 1'b0;
    waitOut(1'b1, 10, n);
    checkRange("R2 power low asserts", n, 2, 4);
    repeat (50) @(negedge clk);
    pwrGood = 1'b1;
    waitOut(1'b0, 1500, n);
    checkRange("R2 power return hold", n, HOLD_CYC, HOLD_CYC + 12);

    // R9: new cause during hold restarts it
    curReq = "R9";
    pbN = 1'b0;
    repeat (100) @(negedge clk);
    pbN = 1'b1;
    repeat (500) @(negedge clk);
    checkEq("R9 still held mid-hold", rstOut, 1);
    pwrGood = 1'b0;
    repeat (10) @(negedge clk);
    pwrGood = 1'b1;
    waitOut(1'b0, 1500, n);
    checkRange("R9 hold restarted from power return", n, HOLD_CYC, HOLD_CYC + 12);
    checkEq("R8 complement after release", rstOutN, 1);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule